// File: doc/BRIEF.md
# Interleaved Intra Prediction Job Scheduler

This controller sequences the prediction work for one macroblock onto a single shared prediction core. It hands out jobs one at a time over a valid/ready handshake. A job is one 4x4 luma block, one 8x8 luma block, one 16x16 luma mode or one chroma mode. Each job carries the index of the quantization parameter (QP) pass it belongs to.

The issue order is fixed, and 4x4 blocks are interleaved with the other job kinds. While a 4x4 block waits for its neighbours to return from the reconstruction loop, the core works on jobs that have no such dependency. The scheduler keeps one 16-bit completion vector per QP pass and fills it from reconstruction-done pulses. A 4x4 job is held back, with valid low, until the neighbours it needs are marked complete for the same QP.

The first pass issues all 28 jobs. Every further pass repeats only the 4x4 and 8x8 jobs. A one-cycle done pulse closes the macroblock.

Top module: `intra_job_sched`

## Requirements
- R1: After reset `job_valid_o` and `mb_done_o` are low.
- R2: Pass 0 issues 28 jobs. Types are 0=4x4, 1=8x8, 2=16x16 luma, 3=chroma. Modes in `job_idx_o` are 0=horizontal, 1=vertical, 2=DC, 3=plane. The order is: 4x4 0, 8x8 0, 4x4 1, luma H, luma V, 4x4 2, 4x4 4, 8x8 1, 4x4 3, 4x4 5, luma DC, 4x4 8, 4x4 6, luma plane, 4x4 9, 4x4 7, chroma H, chroma V, 4x4 10, 4x4 12, 8x8 2, 4x4 11, 4x4 13, chroma DC, chroma plane, 4x4 14, 8x8 3, 4x4 15.
- R3: Each later pass issues the pass-0 order with all 16x16 luma and chroma jobs removed (20 jobs). Luma and chroma jobs therefore only ever carry QP index 0.
- R4: `num_qp_i` is sampled at macroblock start and gives the number of passes. A value of 0 is treated as 1, and values are capped at NQP_MAX (7). Every job of pass k carries `job_qp_o` = k.
- R5: A 4x4 job with Z-scan index b has coordinates x = {b[2],b[0]} and y = {b[3],b[1]}. It is issued only when the following neighbours inside the macroblock have been reported complete for the job's own QP: the left block (x-1,y), the upper block (x,y-1), and the upper-right block (x+1,y-1) when that block's Z-scan index is below b. Until then `job_valid_o` stays low.
- R6: 8x8, 16x16 luma and chroma jobs are issued without regard to reconstruction state.
- R7: While `job_valid_o` is high and `job_ready_i` is low, the job outputs stay unchanged.
- R8: `mb_done_o` is high for exactly one cycle, in the cycle after the last job of the last pass is accepted. No job is offered at that point.
- R9: A macroblock start clears all completion flags, so completions from an earlier macroblock do not release 4x4 jobs.
- R10: A macroblock start pulse while a macroblock is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mb_start_i | input | 1 | Starts a macroblock when idle |
| num_qp_i | input | QP_W | Number of QP passes |
| recon_valid_i | input | 1 | Reconstruction of one 4x4 block finished |
| recon_blk_i | input | 4 | Z-scan index of the finished block |
| recon_qp_i | input | QP_W | QP pass of the finished block |
| job_ready_i | input | 1 | Core accepts the offered job |
| job_valid_o | output | 1 | A job is offered |
| job_type_o | output | 2 | Job type |
| job_idx_o | output | 4 | Block index or mode |
| job_qp_o | output | QP_W | QP pass index |
| mb_done_o | output | 1 | One-cycle end of macroblock |

## Verification
Full macroblocks are run with pass counts of 1, 3 and 7, and with 0. These separate the first-pass order from the reduced repeat order, check the per-pass QP tag, and show that a zero count still yields one pass. A run with reconstruction withheld shows several things: 4x4 jobs stall on left, upper and upper-right neighbours, independent jobs keep flowing during a stall, a completion tagged with the wrong QP releases nothing, and flags left over from the previous macroblock are gone. A back-pressure run holds the ready input low to show that the offered job is kept.

// File: rtl/intra_sched_pkg.sv
package intra_sched_pkg;
  typedef enum logic [1:0] {
    JOB_B4  = 2'd0,
    JOB_B8  = 2'd1,
    JOB_L16 = 2'd2,
    JOB_CHR = 2'd3
  } job_kind_e;

  localparam logic [3:0] MODE_H  = 4'd0;
  localparam logic [3:0] MODE_V  = 4'd1;
  localparam logic [3:0] MODE_DC = 4'd2;
  localparam logic [3:0] MODE_PL = 4'd3;

  localparam int FULL_LEN = 28;
  localparam int REP_LEN  = 20;
  localparam int SLOT_W   = $clog2(FULL_LEN);

  typedef struct packed {
    job_kind_e  kind;
    logic [3:0] idx;
  } job_t;

  function automatic job_t mk(job_kind_e k, logic [3:0] i);
    job_t j;
    j.kind = k;
    j.idx  = i;
    return j;
  endfunction
endpackage

// File: rtl/intra_job_order.sv
module intra_job_order
  import intra_sched_pkg::*;
(
  input  logic              first_pass_i,
  input  logic [SLOT_W-1:0] slot_i,
  output job_t              job_o,
  output logic              last_o
);
  job_t full_job, rep_job;

  always_comb begin
    unique case (slot_i)
      5'd0:  full_job = mk(JOB_B4, 4'd0);
      5'd1:  full_job = mk(JOB_B8, 4'd0);
      5'd2:  full_job = mk(JOB_B4, 4'd1);
      5'd3:  full_job = mk(JOB_L16, MODE_H);
      5'd4:  full_job = mk(JOB_L16, MODE_V);
      5'd5:  full_job = mk(JOB_B4, 4'd2);
      5'd6:  full_job = mk(JOB_B4, 4'd4);
      5'd7:  full_job = mk(JOB_B8, 4'd1);
      5'd8:  full_job = mk(JOB_B4, 4'd3);
      5'd9:  full_job = mk(JOB_B4, 4'd5);
      5'd10: full_job = mk(JOB_L16, MODE_DC);
      5'd11: full_job = mk(JOB_B4, 4'd8);
      5'd12: full_job = mk(JOB_B4, 4'd6);
      5'd13: full_job = mk(JOB_L16, MODE_PL);
      5'd14: full_job = mk(JOB_B4, 4'd9);
      5'd15: full_job = mk(JOB_B4, 4'd7);
      5'd16: full_job = mk(JOB_CHR, MODE_H);
      5'd17: full_job = mk(JOB_CHR, MODE_V);
      5'd18: full_job = mk(JOB_B4, 4'd10);
      5'd19: full_job = mk(JOB_B4, 4'd12);
      5'd20: full_job = mk(JOB_B8, 4'd2);
      5'd21: full_job = mk(JOB_B4, 4'd11);
      5'd22: full_job = mk(JOB_B4, 4'd13);
      5'd23: full_job = mk(JOB_CHR, MODE_DC);
      5'd24: full_job = mk(JOB_CHR, MODE_PL);
      5'd25: full_job = mk(JOB_B4, 4'd14);
      5'd26: full_job = mk(JOB_B8, 4'd3);
      default: full_job = mk(JOB_B4, 4'd15);
    endcase
  end

  // repeat passes: same order without luma 16x16 and chroma jobs
  always_comb begin
    unique case (slot_i)
      5'd0:  rep_job = mk(JOB_B4, 4'd0);
      5'd1:  rep_job = mk(JOB_B8, 4'd0);
      5'd2:  rep_job = mk(JOB_B4, 4'd1);
      5'd3:  rep_job = mk(JOB_B4, 4'd2);
      5'd4:  rep_job = mk(JOB_B4, 4'd4);
      5'd5:  rep_job = mk(JOB_B8, 4'd1);
      5'd6:  rep_job = mk(JOB_B4, 4'd3);
      5'd7:  rep_job = mk(JOB_B4, 4'd5);
      5'd8:  rep_job = mk(JOB_B4, 4'd8);
      5'd9:  rep_job = mk(JOB_B4, 4'd6);
      5'd10: rep_job = mk(JOB_B4, 4'd9);
      5'd11: rep_job = mk(JOB_B4, 4'd7);
      5'd12: rep_job = mk(JOB_B4, 4'd10);
      5'd13: rep_job = mk(JOB_B4, 4'd12);
      5'd14: rep_job = mk(JOB_B8, 4'd2);
      5'd15: rep_job = mk(JOB_B4, 4'd11);
      5'd16: rep_job = mk(JOB_B4, 4'd13);
      5'd17: rep_job = mk(JOB_B4, 4'd14);
      5'd18: rep_job = mk(JOB_B8, 4'd3);
      default: rep_job = mk(JOB_B4, 4'd15);
    endcase
  end

  assign job_o  = first_pass_i ? full_job : rep_job;
  assign last_o = first_pass_i ? (slot_i == SLOT_W'(FULL_LEN - 1))
                               : (slot_i == SLOT_W'(REP_LEN - 1));
endmodule

// File: rtl/intra_dep_check.sv
module intra_dep_check (
  input  logic [3:0]  blk_i,
  input  logic [15:0] done_i,
  output logic        ready_o
);
  function automatic logic [3:0] zidx(logic [1:0] x, logic [1:0] y);
    return {y[1], x[1], y[0], x[0]};
  endfunction

  logic [1:0] x, y, xl, xr, yu;
  assign x  = {blk_i[2], blk_i[0]};
  assign y  = {blk_i[3], blk_i[1]};
  assign xl = x - 2'd1;
  assign xr = x + 2'd1;
  assign yu = y - 2'd1;

  always_comb begin
    ready_o = 1'b1;
    if (x != 2'd0) ready_o = ready_o & done_i[zidx(xl, y)];
    if (y != 2'd0) begin
      ready_o = ready_o & done_i[zidx(x, yu)];
      // upper-right only counts when it precedes this block in Z-scan
      if (x != 2'd3 && zidx(xr, yu) < blk_i)
        ready_o = ready_o & done_i[zidx(xr, yu)];
    end
  end
endmodule

// File: rtl/intra_recon_flags.sv
module intra_recon_flags #(
  parameter int NQP_MAX = 7,
  localparam int QP_W = $clog2(NQP_MAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    set_i,
  input  logic [QP_W-1:0]         set_qp_i,
  input  logic [3:0]              set_blk_i,
  output logic [NQP_MAX-1:0][15:0] flags_o
);
  for (genvar q = 0; q < NQP_MAX; q++) begin : g_qp
    logic hit;
    assign hit = set_i && (set_qp_i == QP_W'(q));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flags_o[q] <= '0;
      else if (clr_i)   flags_o[q] <= '0;
      else if (hit)     flags_o[q][set_blk_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/intra_job_sched.sv
module intra_job_sched
  import intra_sched_pkg::*;
#(
  parameter int NQP_MAX = 7,
  localparam int QP_W = $clog2(NQP_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mb_start_i,
  input  logic [QP_W-1:0] num_qp_i,
  input  logic            recon_valid_i,
  input  logic [3:0]      recon_blk_i,
  input  logic [QP_W-1:0] recon_qp_i,
  input  logic            job_ready_i,
  output logic            job_valid_o,
  output logic [1:0]      job_type_o,
  output logic [3:0]      job_idx_o,
  output logic [QP_W-1:0] job_qp_o,
  output logic            mb_done_o
);
  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [QP_W-1:0]   qp_q, nqp_q, nqp_d;
  logic [NQP_MAX-1:0][15:0] flags;
  job_t              cur;
  logic              last_slot, dep_ok, accept, start, last_pass;

  assign start = mb_start_i && !run_q;

  always_comb begin
    if (num_qp_i == '0)                      nqp_d = QP_W'(1);
    else if (num_qp_i > QP_W'(NQP_MAX))      nqp_d = QP_W'(NQP_MAX);
    else                                     nqp_d = num_qp_i;
  end

  intra_recon_flags #(.NQP_MAX(NQP_MAX)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start),
    .set_i     (recon_valid_i),
    .set_qp_i  (recon_qp_i),
    .set_blk_i (recon_blk_i),
    .flags_o   (flags)
  );

  intra_job_order u_order (
    .first_pass_i (qp_q == '0),
    .slot_i       (slot_q),
    .job_o        (cur),
    .last_o       (last_slot)
  );

  intra_dep_check u_dep (
    .blk_i   (cur.idx),
    .done_i  (flags[qp_q]),
    .ready_o (dep_ok)
  );

  assign job_valid_o = run_q && (cur.kind != JOB_B4 || dep_ok);
  assign accept      = job_valid_o && job_ready_i;
  assign last_pass   = (qp_q == nqp_q - QP_W'(1));
  assign job_type_o  = cur.kind;
  assign job_idx_o   = cur.idx;
  assign job_qp_o    = qp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      slot_q    <= '0;
      qp_q      <= '0;
      nqp_q     <= QP_W'(1);
      mb_done_o <= 1'b0;
    end else begin
      mb_done_o <= accept && last_slot && last_pass;
      if (start) begin
        run_q  <= 1'b1;
        slot_q <= '0;
        qp_q   <= '0;
        nqp_q  <= nqp_d;
      end else if (accept) begin
        if (last_slot) begin
          slot_q <= '0;
          if (last_pass) run_q <= 1'b0;
          else           qp_q  <= qp_q + QP_W'(1);
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/intra_job_sched_chk.sv
module intra_job_sched_chk #(
  parameter int NQP_MAX = 7,
  localparam int QP_W = $clog2(NQP_MAX + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mb_start_i,
  input logic [QP_W-1:0] num_qp_i,
  input logic            recon_valid_i,
  input logic [3:0]      recon_blk_i,
  input logic [QP_W-1:0] recon_qp_i,
  input logic            job_ready_i,
  input logic            job_valid_o,
  input logic [1:0]      job_type_o,
  input logic [3:0]      job_idx_o,
  input logic [QP_W-1:0] job_qp_o,
  input logic            mb_done_o
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && !job_ready_i |=> job_valid_o && $stable(job_type_o)
      && $stable(job_idx_o) && $stable(job_qp_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |=> !mb_done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |-> !job_valid_o);

  p_once_per_mb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && job_type_o[1] |-> job_qp_o == '0);

  p_qp_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o |-> job_qp_o < QP_W'(NQP_MAX));

  p_first_blk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && job_type_o == 2'd0 && job_idx_o == 4'd0 && job_qp_o == '0
      && job_ready_i |=> !mb_done_o);
endmodule

bind intra_job_sched intra_job_sched_chk #(.NQP_MAX(NQP_MAX)) u_chk (.*);

// File: tb/intra_job_sched_tb.sv
module intra_job_sched_tb;
  localparam int NQP = 7;
  localparam int QW  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mb_start_i = 1'b0;
  logic [QW-1:0] num_qp_i = '0;
  logic recon_valid_i = 1'b0;
  logic [3:0] recon_blk_i = '0;
  logic [QW-1:0] recon_qp_i = '0;
  logic job_ready_i = 1'b0;
  logic job_valid_o, mb_done_o;
  logic [1:0] job_type_o;
  logic [3:0] job_idx_o;
  logic [QW-1:0] job_qp_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // expected pass-0 order, encoded as type*16 + index
  int full_ord[28] = '{0, 16, 1, 32, 33, 2, 4, 17, 3, 5, 34, 8, 6, 35, 9, 7,
                       48, 49, 10, 12, 18, 11, 13, 50, 51, 14, 19, 15};
  int rep_ord[20];

  always #10 clk = ~clk;

  intra_job_sched #(.NQP_MAX(NQP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mb_start_i(mb_start_i), .num_qp_i(num_qp_i),
    .recon_valid_i(recon_valid_i), .recon_blk_i(recon_blk_i), .recon_qp_i(recon_qp_i),
    .job_ready_i(job_ready_i), .job_valid_o(job_valid_o), .job_type_o(job_type_o),
    .job_idx_o(job_idx_o), .job_qp_o(job_qp_o), .mb_done_o(mb_done_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cur_job();
    return int'(job_type_o) * 16 + int'(job_idx_o);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    mb_start_i = 1'b0; recon_valid_i = 1'b0; job_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_mb(int nqp);
    mb_start_i = 1'b1;
    num_qp_i = QW'(nqp);
    @(negedge clk);
    mb_start_i = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1", "valid after reset", job_valid_o, 0);
    chk("R1", "done after reset", mb_done_o, 0);
  endtask

  // full macroblock, reconstruction reported one cycle after each 4x4 accept
  task automatic run_mb(int nqp_in, int passes);
    int total = 28 + 20 * (passes - 1);
    int e = 0;
    int bad = 0;
    bit pend = 0;
    logic [3:0] pb = '0;
    logic [QW-1:0] pq = '0;
    start_mb(nqp_in);
    while (e < total) begin
      recon_valid_i = 1'b0;
      if (pend) begin
        recon_valid_i = 1'b1; recon_blk_i = pb; recon_qp_i = pq; pend = 0;
      end
      job_ready_i = 1'b1;
      if (job_valid_o) begin
        int pass = (e < 28) ? 0 : 1 + (e - 28) / 20;
        int pos  = (e < 28) ? e : (e - 28) % 20;
        int exp  = (pass == 0) ? full_ord[pos] : rep_ord[pos];
        if (cur_job() != exp || int'(job_qp_o) != pass) bad++;
        chk(pass == 0 ? "R2" : "R3", "job", cur_job(), exp);
        chk("R4", "qp tag", int'(job_qp_o), pass);
        if (job_type_o == 2'd0) begin pend = 1; pb = job_idx_o; pq = job_qp_o; end
        e++;
        chk("R8", "early done", mb_done_o, 0);
      end
      if (e < total) @(negedge clk);
    end
    @(negedge clk);
    job_ready_i = 1'b0;
    recon_valid_i = pend;
    recon_blk_i = pb; recon_qp_i = pq;
    chk("R8", "done pulse", mb_done_o, 1);
    chk("R8", "idle at done", job_valid_o, 0);
    @(negedge clk);
    recon_valid_i = 1'b0;
    chk("R8", "done one cycle", mb_done_o, 0);
    chk("R4", "pass count clean", bad, 0);
  endtask

  task automatic pulse_recon(int blk, int qp);
    recon_valid_i = 1'b1; recon_blk_i = 4'(blk); recon_qp_i = QW'(qp);
    @(negedge clk);
    recon_valid_i = 1'b0;
  endtask

  // reconstruction withheld; flags of the previous macroblock must be gone
  task automatic test_stall();
    job_ready_i = 1'b1;
    start_mb(1);
    chk("R5", "4x4 0 free", cur_job(), 0);
    chk("R5", "4x4 0 valid", job_valid_o, 1);
    @(negedge clk);
    chk("R6", "8x8 0 flows", cur_job() + 100 * job_valid_o, 116);
    @(negedge clk);
    chk("R9", "4x4 1 blocked after start", job_valid_o, 0);
    mb_start_i = 1'b1; num_qp_i = 3'd1;
    @(negedge clk);
    mb_start_i = 1'b0;
    chk("R5", "still blocked", job_valid_o, 0);
    @(negedge clk);
    chk("R5", "still blocked 2", job_valid_o, 0);
    pulse_recon(0, 0);
    chk("R10", "order kept after ignored start", cur_job() + 100 * job_valid_o, 101);
    @(negedge clk);
    chk("R6", "luma H without recon", cur_job() + 100 * job_valid_o, 132);
    @(negedge clk);
    chk("R6", "luma V", cur_job() + 100 * job_valid_o, 133);
    @(negedge clk);
    chk("R5", "4x4 2 waits upper-right", job_valid_o, 0);
    pulse_recon(1, 1);
    chk("R5", "other qp ignored", job_valid_o, 0);
    pulse_recon(1, 0);
    chk("R5", "4x4 2 released", cur_job() + 100 * job_valid_o, 102);
    job_ready_i = 1'b0;
  endtask

  task automatic test_hold();
    do_reset();
    job_ready_i = 1'b0;
    start_mb(2);
    for (int i = 0; i < 3; i++) begin
      chk("R7", "held valid", job_valid_o, 1);
      chk("R7", "held job", cur_job() * 8 + int'(job_qp_o), 0);
      @(negedge clk);
    end
    job_ready_i = 1'b1;
    @(negedge clk);
    chk("R7", "advances on ready", cur_job() + 100 * job_valid_o, 116);
    job_ready_i = 1'b0;
  endtask

  initial begin
    int k = 0;
    foreach (full_ord[i]) if (full_ord[i] < 32) begin rep_ord[k] = full_ord[i]; k++; end
    test_reset();
    run_mb(1, 1);
    test_stall();
    do_reset();
    run_mb(3, 3);
    run_mb(7, 7);
    run_mb(0, 1);
    test_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule